// File: doc/BRIEF.md
# Bit-Serial Adder with Sequencing Control

This block adds two unsigned operands one bit position per clock, reusing a single full-adder cell across time instead of a ripple chain. A load request copies both operands into two shift registers at once. A controller then shifts them out for exactly `WIDTH` clocks, least significant bit first, into the full adder. Each sum bit enters a sum shift register from the top. The carry waits in a flip-flop until the next bit time.

When the last bit has been shifted, the controller raises `done` for one clock. At that point `sumOut` holds the low `WIDTH` bits of the sum and `carryOut` holds the carry out of the top bit. A caller pulses or holds `loadReq` with the operands, waits for `done`, and reads the result. The result stays on the outputs until the next load. The width is a parameter, with a default of 4 and a minimum of 2.

Top module: `bit_serial_adder`

## Requirements
- R1: When the block is not shifting, a high `loadReq` at a rising clock edge captures `opA` and `opB` in parallel. The addition then uses exactly those values.
- R2: While `rstN` is low, the carry flip-flop is cleared and the controller returns to idle. After reset, `carryOut` reads 0 and `done` reads 0 until a load is accepted.
- R3: When `done` is high, `sumOut` equals (`opA` + `opB`) mod 2^WIDTH for the captured operands. Bit 0 of the sum is in bit position 0.
- R4: When `done` is high, `carryOut` equals bit WIDTH of `opA` + `opB`.
- R5: Accepting a load clears the carry. An addition that follows one ending with carry 1 therefore starts with carry-in 0.
- R6: If the load is accepted at edge k, `done` is low after edges k+1 through k+WIDTH-1 and high after edge k+WIDTH.
- R7: `done` stays high for exactly one clock. After it falls, `sumOut` and `carryOut` keep their values while no load is accepted.
- R8: A high `loadReq` during the WIDTH shift cycles is ignored. The running addition keeps its operands and its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| loadReq | input | 1 | Request to capture operands and start an addition |
| opA | input | WIDTH | First operand, unsigned |
| opB | input | WIDTH | Second operand, unsigned |
| sumOut | output | WIDTH | Sum register contents |
| carryOut | output | 1 | Carry flip-flop contents, the final carry when `done` is high |
| done | output | 1 | One-clock flag marking a finished addition |

## Verification
The hardest condition to reach from the ports is a load request that arrives while the shift sequence is partway through. The stimulus also drives different operands at that moment, so a design that takes the request would produce a visibly wrong sum or shifted `done` timing. The bench produces this by raising `loadReq` with new operands a few clocks after a load has been accepted. A second hard case is carry leakage between additions. An addition that ends with carry 1 is followed immediately by 0 + 0, so any carry left behind shows up in the second result.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;   // parallel capture of operands, clear carry
    logic shift;  // one bit time through the full adder
  } bsaStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } bsaState_t;

endpackage

// File: rtl/bsa_full_adder.sv
module bsa_full_adder (
  input  logic a,
  input  logic b,
  input  logic cIn,
  output logic s,
  output logic cOut
);

  always_comb begin
    s    = a ^ b ^ cIn;
    cOut = (a & b) | (a & cIn) | (b & cIn);
  end

endmodule

// File: rtl/bsa_datapath.sv
module bsa_datapath
  import bsa_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  bsaStrobe_t       ctl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumQ,
  output logic             carryQ
);

  logic [WIDTH-1:0] aQ;
  logic [WIDTH-1:0] bQ;
  logic             sumBit;
  logic             carryNext;

  // The single adder cell, reused every bit time
  bsa_full_adder uFa (
    .a    (aQ[0]),
    .b    (bQ[0]),
    .cIn  (carryQ),
    .s    (sumBit),
    .cOut (carryNext)
  );

  // Operand and sum shift registers: no reset, a load overwrites them
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : gBit
      if (i == WIDTH - 1) begin : gTop
        always_ff @(posedge clk) begin
          if (ctl.load) begin
            aQ[i] <= opA[i];
            bQ[i] <= opB[i];
          end else if (ctl.shift) begin
            aQ[i] <= 1'b0;
            bQ[i] <= 1'b0;
          end
          if (ctl.shift) sumQ[i] <= sumBit;
        end
      end else begin : gLow
        always_ff @(posedge clk) begin
          if (ctl.load) begin
            aQ[i] <= opA[i];
            bQ[i] <= opB[i];
          end else if (ctl.shift) begin
            aQ[i] <= aQ[i+1];
            bQ[i] <= bQ[i+1];
          end
          if (ctl.shift) sumQ[i] <= sumQ[i+1];
        end
      end
    end
  endgenerate

  // Carry storage between bit times
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          carryQ <= 1'b0;
    else if (ctl.load)  carryQ <= 1'b0;
    else if (ctl.shift) carryQ <= carryNext;
  end

  // R1: operands captured in parallel on an accepted load
  a_r1_parallel_capture : assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (aQ == $past(opA)) && (bQ == $past(opB)));

  // R5: carry starts at zero for every addition
  a_r5_load_clears_carry : assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (carryQ == 1'b0));

  // R7: sum register holds while no bit time runs
  a_r7_sum_holds : assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.shift && !$isunknown(sumQ)) |=> $stable(sumQ));

endmodule

// File: rtl/bsa_control.sv
module bsa_control
  import bsa_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadReq,
  output bsaStrobe_t ctl,
  output logic       done
);

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  bsaState_t     state;
  bsaState_t     stateNext;
  logic [CW-1:0] bitCnt;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (loadReq) begin
          ctl.load  = 1'b1;
          stateNext = ST_SHIFT;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      ST_SHIFT: begin
        ctl.shift = 1'b1;
        if (bitCnt == LAST) stateNext = ST_DONE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state <= stateNext;
      if (ctl.load)       bitCnt <= '0;
      else if (ctl.shift) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign done = (state == ST_DONE);

  // R7: completion flag is a single-cycle pulse
  a_r7_done_one_cycle : assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: a running sequence advances one bit per clock and is not restarted
  a_r8_shift_uninterrupted : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT && bitCnt != LAST) |=>
      (state == ST_SHIFT && bitCnt == $past(bitCnt) + 1'b1));

endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder
  import bsa_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadReq,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic             done
);

  localparam int SCW = $clog2(WIDTH + 1);

  bsaStrobe_t ctl;

  bsa_control #(.WIDTH(WIDTH)) uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .loadReq (loadReq),
    .ctl     (ctl),
    .done    (done)
  );

  bsa_datapath #(.WIDTH(WIDTH)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .opA    (opA),
    .opB    (opB),
    .sumQ   (sumOut),
    .carryQ (carryOut)
  );

  // Checker counter: bit times seen since the last accepted load
  logic [SCW-1:0] shiftsSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          shiftsSeen <= '0;
    else if (ctl.load)  shiftsSeen <= '0;
    else if (ctl.shift) shiftsSeen <= shiftsSeen + 1'b1;
  end

  // R6: completion comes after exactly WIDTH bit times
  a_r6_done_after_width : assert property (@(posedge clk) disable iff (!rstN)
    done |-> (shiftsSeen == SCW'(WIDTH)));

  // R2: no completion flag without a preceding load
  a_r2_no_spurious_done : assert property (@(posedge clk) disable iff (!rstN)
    (shiftsSeen == '0) |-> !done);

endmodule

// File: tb/tb_bit_serial_adder.sv
`timescale 1ns/1ps
module tb_bit_serial_adder;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         loadReq = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] sumOut;
  logic         carryOut;
  logic         done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bit_serial_adder #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .loadReq(loadReq),
    .opA(opA), .opB(opB),
    .sumOut(sumOut), .carryOut(carryOut), .done(done)
  );

  // {a, b, carry, sum}
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {4'd3,  4'd5,  1'b0, 4'd8},
    {4'd15, 4'd1,  1'b1, 4'd0},
    {4'd15, 4'd15, 1'b1, 4'd14},
    {4'd0,  4'd0,  1'b0, 4'd0},
    {4'd9,  4'd7,  1'b1, 4'd0},
    {4'd10, 4'd5,  1'b0, 4'd15},
    {4'd12, 4'd6,  1'b1, 4'd2},
    {4'd8,  4'd8,  1'b1, 4'd0}
  };

  task automatic chk(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Issue a load, then step through the bit times checking timing and result.
  // midA/midB: if midReq, loadReq is raised with these during shifting (R8).
  task automatic runAdd(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic expC, input logic [W-1:0] expS,
                        input logic midReq, input logic [W-1:0] midA,
                        input logic [W-1:0] midB);
    @(negedge clk);
    opA = a; opB = b; loadReq = 1'b1;
    @(posedge clk);              // load edge k
    @(negedge clk);
    loadReq = 1'b0;
    for (int i = 1; i <= W; i++) begin
      if (midReq && i == 2) begin
        opA = midA; opB = midB; loadReq = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      if (i < W) chk("R6 done early", {{W{1'b0}}, done}, '0);
    end
    loadReq = 1'b0;
    chk("R6 done at k+W", {{W{1'b0}}, done}, {{W{1'b0}}, 1'b1});
    chk("R3 sum", {1'b0, sumOut}, {1'b0, expS});
    chk("R4 carry", {{W{1'b0}}, carryOut}, {{W{1'b0}}, expC});
    @(posedge clk);
    @(negedge clk);
    chk("R7 done one cycle", {{W{1'b0}}, done}, '0);
    chk("R7 result held", {carryOut, sumOut}, {expC, expS});
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 reset carry", {{W{1'b0}}, carryOut}, '0);
    chk("R2 reset done", {{W{1'b0}}, done}, '0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 idle after reset", {carryOut, done}, '0);

    // R1 R3 R4 R6 R7: table walk
    for (int v = 0; v < NV; v++) begin
      runAdd(VEC[v][12:9], VEC[v][8:5], VEC[v][4], VEC[v][3:0], 1'b0, '0, '0);
    end

    // R5: carry 1 result followed directly by 0 + 0
    runAdd(4'd15, 4'd15, 1'b1, 4'd14, 1'b0, '0, '0);
    runAdd(4'd0, 4'd0, 1'b0, 4'd0, 1'b0, '0, '0);
    chk("R5 carry cleared by load", {{W{1'b0}}, carryOut}, '0);

    // R8: load request with other operands during shifting is ignored
    runAdd(4'd6, 4'd7, 1'b0, 4'd13, 1'b1, 4'd15, 4'd15);
    // R1: capture exactly the presented operands after that
    runAdd(4'd1, 4'd2, 1'b0, 4'd3, 1'b0, '0, '0);

    // R2: reset in the middle of an addition
    @(negedge clk);
    opA = 4'd15; opB = 4'd15; loadReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    loadReq = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R2 mid reset carry", {{W{1'b0}}, carryOut}, '0);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < W + 2; i++) begin
      @(negedge clk);
      chk("R2 no done after reset", {{W{1'b0}}, done}, '0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule